// File: doc/BRIEF.md
# Serial-Clocked Wiper Tap Stepper

This block moves digital potentiometer wiper positions one tap at a time under serial-clock control. A command decoder upstream recognizes the step command. It pulses `cmd_start` together with the wiper index. From then on, every rising serial-clock strobe moves the chosen wiper one position. The level of the serial data input at that strobe sets the direction: high steps toward the top tap, low steps toward the bottom tap. There is no data byte. Stepping continues for any number of strobes until the chip select is released.

Each wiper is an unsigned tap index of `TAP_W` bits, so the default has 256 positions from 0 to 255. Steps stop at both ends and never wrap. The block only changes the live wiper registers. It never touches any stored setting.

Each real change of a wiper starts a settle timer. After `SETTLE_CYC` clocks with no further change, the timer fires a one-cycle `settle_done` strobe. This stands for the analog response delay of the wiper. Every pin is plain control or status; there is no valid/ready stream at this block's edge, so back-pressure does not arise.

Top module: `wiper_stepper`

## Requirements
- R1: While `rst_n` is low, every wiper is set to `INIT_TAP`, `settle_done` is 0 and stepping mode is off.
- R2: Stepping mode starts on a clock where `cmd_start` is 1 and `cs_n` is 0. That clock latches `cmd_sel` as the wiper to move. A `sck_rise` strobe seen while the mode is off changes no wiper.
- R3: In stepping mode, a `sck_rise` strobe with `si` = 1 raises the selected wiper by exactly one. The new value is visible on `wiper_taps` one clock after the strobe.
- R4: In stepping mode, a `sck_rise` strobe with `si` = 0 lowers the selected wiper by exactly one, with the same one-clock latency.
- R5: A step up from the all-ones tap leaves the wiper unchanged, and a step down from tap 0 leaves it unchanged. No wiper ever wraps.
- R6: Only the wiper latched by R2 moves. Wiper `i` occupies bits `[i*TAP_W +: TAP_W]` of `wiper_taps`.
- R7: `cs_n` = 1 ends stepping mode. Strobes in a clock with `cs_n` = 1 are ignored. Strobes after `cs_n` returns low are also ignored until a new `cmd_start`.
- R8: `settle_done` pulses for one clock exactly `SETTLE_CYC` clocks after the last wiper change. A newer change restarts the count. A step that leaves the wiper unchanged (R5) starts no count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | One-clock pulse: the step command was decoded |
| cmd_sel | input | SEL_W | Wiper index given with the command |
| cs_n | input | 1 | Chip select, active low; high ends the mode |
| sck_rise | input | 1 | One-clock strobe per serial clock rising edge |
| si | input | 1 | Serial data level; 1 = up, 0 = down |
| wiper_taps | output | NUM_POTS*TAP_W | All wiper positions, wiper 0 in the low bits |
| settle_done | output | 1 | One-clock strobe when the wiper output has settled |

## Verification
A step strobe applied in clock N shows on `wiper_taps` after the edge that ends clock N. The monitor samples a quarter period after that edge and compares the bus against the scoreboard entry the driver queued with the strobe. The settle strobe is due `SETTLE_CYC` clocks after the change edge. The bench counts falling edges from the change and requires the first `settle_done` at exactly that count. A saturated step must produce no pulse in a window two clocks longer.

// File: rtl/stepper_pkg.sv
package stepper_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } step_dir_e;
endpackage

// File: rtl/step_mode_ctl.sv
module step_mode_ctl #(
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [SEL_W-1:0] cmd_sel,
  input  logic             cs_n,
  input  logic             sck_rise,
  output logic             mode_on,
  output logic [SEL_W-1:0] sel_q,
  output logic             step_go
);
  // Mode is armed by the command and dropped by deselect.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_on <= 1'b0;
      sel_q   <= '0;
    end else if (cs_n) begin
      mode_on <= 1'b0;
    end else if (cmd_start) begin
      mode_on <= 1'b1;
      sel_q   <= cmd_sel;
    end
  end

  assign step_go = mode_on && !cs_n && sck_rise;
endmodule

// File: rtl/tap_reg.sv
module tap_reg
  import stepper_pkg::*;
#(
  parameter int TAP_W    = 8,
  parameter int INIT_TAP = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  step_dir_e        dir,
  output logic [TAP_W-1:0] tap,
  output logic             moved
);
  localparam logic [TAP_W-1:0] TOP_TAP = {TAP_W{1'b1}};
  localparam logic [TAP_W-1:0] RST_TAP = INIT_TAP[TAP_W-1:0];

  logic at_top, at_bot;
  assign at_top = (tap == TOP_TAP);
  assign at_bot = (tap == '0);
  // A step at an end stop is swallowed.
  assign moved  = go && ((dir == DIR_UP) ? !at_top : !at_bot);

  always_ff @(posedge clk) begin
    if (!rst_n)
      tap <= RST_TAP;
    else if (moved)
      tap <= (dir == DIR_UP) ? tap + 1'b1 : tap - 1'b1;
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic done
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= (cnt == CW'(1)) && !kick;
      if (kick)
        cnt <= LOAD;
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wiper_stepper.sv
module wiper_stepper
  import stepper_pkg::*;
#(
  parameter int NUM_POTS   = 2,
  parameter int TAP_W      = 8,
  parameter int INIT_TAP   = 128,
  parameter int SETTLE_CYC = 20,
  localparam int SEL_W     = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_start,
  input  logic [SEL_W-1:0]          cmd_sel,
  input  logic                      cs_n,
  input  logic                      sck_rise,
  input  logic                      si,
  output logic [NUM_POTS*TAP_W-1:0] wiper_taps,
  output logic                      settle_done
);
  logic             mode_on;
  logic [SEL_W-1:0] sel_q;
  logic             step_go;
  logic [NUM_POTS-1:0] moved_v;
  step_dir_e        dir;

  assign dir = step_dir_e'(si);

  step_mode_ctl #(.SEL_W(SEL_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_sel(cmd_sel),
    .cs_n(cs_n), .sck_rise(sck_rise), .mode_on(mode_on), .sel_q(sel_q),
    .step_go(step_go)
  );

  for (genvar i = 0; i < NUM_POTS; i++) begin : g_pot
    tap_reg #(.TAP_W(TAP_W), .INIT_TAP(INIT_TAP)) u_tap (
      .clk(clk), .rst_n(rst_n),
      .go(step_go && (sel_q == SEL_W'(i))),
      .dir(dir),
      .tap(wiper_taps[i*TAP_W +: TAP_W]),
      .moved(moved_v[i])
    );
  end

  settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .kick(|moved_v), .done(settle_done)
  );
endmodule

// File: rtl/wiper_stepper_chk.sv
module wiper_stepper_chk #(
  parameter int NUM_POTS   = 2,
  parameter int TAP_W      = 8,
  parameter int SETTLE_CYC = 20
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cs_n,
  input logic                      mode_on,
  input logic [NUM_POTS*TAP_W-1:0] wiper_taps,
  input logic                      settle_done
);
  // R7
  deselect_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(wiper_taps));

  // R2
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_on |=> $stable(wiper_taps));

  // R8
  settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settle_done |-> $stable(wiper_taps));

  for (genvar i = 0; i < NUM_POTS; i++) begin : g_step
    // R5
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wiper_taps[i*TAP_W +: TAP_W] != $past(wiper_taps[i*TAP_W +: TAP_W])) |->
      ((int'(wiper_taps[i*TAP_W +: TAP_W]) - int'($past(wiper_taps[i*TAP_W +: TAP_W])) == 1) ||
       (int'($past(wiper_taps[i*TAP_W +: TAP_W])) - int'(wiper_taps[i*TAP_W +: TAP_W]) == 1)));
  end

  if (SETTLE_CYC > 1) begin : g_pulse
    // R8
    settle_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      settle_done |=> !settle_done);
  end
endmodule

bind wiper_stepper wiper_stepper_chk #(
  .NUM_POTS(NUM_POTS), .TAP_W(TAP_W), .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .mode_on(mode_on),
  .wiper_taps(wiper_taps), .settle_done(settle_done)
);

// File: tb/sim_wiper_stepper.sv
module sim_wiper_stepper;
  localparam int CLK_P = 10;
  localparam int NP    = 2;
  localparam int TW    = 8;
  localparam int STL   = 6;
  localparam int INIT  = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0;
  logic [0:0] cmd_sel = 1'b0;
  logic cs_n = 1'b1;
  logic sck_rise = 1'b0;
  logic si = 1'b0;
  logic [NP*TW-1:0] wiper_taps;
  logic settle_done;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  int  mdl [NP];
  bit  mdl_on = 0;
  int  mdl_sel = 0;

  logic [NP*TW-1:0] q_exp [$];
  string            q_tag [$];

  always #(CLK_P/2) clk = ~clk;

  wiper_stepper #(.NUM_POTS(NP), .TAP_W(TW), .INIT_TAP(INIT), .SETTLE_CYC(STL)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_sel(cmd_sel),
    .cs_n(cs_n), .sck_rise(sck_rise), .si(si),
    .wiper_taps(wiper_taps), .settle_done(settle_done)
  );

  function automatic logic [NP*TW-1:0] packed_model();
    logic [NP*TW-1:0] v;
    for (int i = 0; i < NP; i++) v[i*TW +: TW] = TW'(mdl[i]);
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: one quarter period after each rising edge.
  always @(posedge clk) begin
    #(CLK_P/4);
    if (q_exp.size() > 0) begin
      logic [NP*TW-1:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check(t, int'(wiper_taps), int'(e));
    end
  end

  task automatic step(bit up, string tag);
    @(negedge clk);
    si = up;
    sck_rise = 1'b1;
    if (mdl_on && !cs_n) begin
      if (up && mdl[mdl_sel] < 255) mdl[mdl_sel]++;
      else if (!up && mdl[mdl_sel] > 0) mdl[mdl_sel]--;
    end
    q_exp.push_back(packed_model());
    q_tag.push_back(tag);
    @(negedge clk);
    sck_rise = 1'b0;
  endtask

  task automatic command(int s);
    @(negedge clk);
    cmd_start = 1'b1;
    cmd_sel = 1'(s);
    if (!cs_n) begin mdl_on = 1; mdl_sel = s; end
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic settle_check(bit expect_fire, string tag);
    int first = 0;
    for (int k = 1; k <= STL + 2; k++) begin
      @(negedge clk);
      if (settle_done && first == 0) first = k;
    end
    check(tag, first, expect_fire ? STL : 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) mdl[i] = INIT;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 taps", int'(wiper_taps), int'(packed_model()));
    check("R1 settle", int'(settle_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b0;
    // R2: strobes before the command are ignored
    step(1'b1, "R2 idle strobe");
    step(1'b0, "R2 idle strobe");
    command(1);
    // R3 and R6: pot 1 up, pot 0 untouched
    for (int k = 0; k < 3; k++) step(1'b1, "R3 R6 up");
    check("R6 pot0", int'(wiper_taps[TW-1:0]), INIT);
    // R4 down
    for (int k = 0; k < 5; k++) step(1'b0, "R4 down");
    // R8 restart by newer change, then exact delay
    settle_check(1'b1, "R8 delay");
    // R5 top saturation
    while (mdl[1] < 255) step(1'b1, "R5 climb");
    settle_check(1'b1, "R8 delay at top");
    for (int k = 0; k < 3; k++) step(1'b1, "R5 hold top");
    settle_check(1'b0, "R8 no pulse when held");
    // R7: deselect ends mode
    @(negedge clk);
    cs_n = 1'b1;
    mdl_on = 0;
    step(1'b0, "R7 cs high strobe");
    @(negedge clk);
    cs_n = 1'b0;
    step(1'b0, "R7 after reselect");
    step(1'b1, "R7 after reselect");
    // new command on pot 0, down to bottom
    command(0);
    while (mdl[0] > 0) step(1'b0, "R5 descend");
    for (int k = 0; k < 3; k++) step(1'b0, "R5 hold bottom");
    step(1'b1, "R3 leave bottom");
    check("R6 pot1", int'(wiper_taps[2*TW-1:TW]), 255);
    repeat (3) @(negedge clk);
    check("R5 queue drained", q_exp.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule